// File: doc/BRIEF.md
# BFloat16 Atomic Maximum Unit

This unit carries out one indivisible read-modify-write on a 16-bit memory word. It reads the halfword at the requested address and takes the BFloat16 maximum of that halfword and a 16-bit operand. It then writes the larger value back to the same address. The old contents are dropped and nothing goes back to the register file. The floating-point controls are fixed: every NaN result is the canonical quiet NaN, the unit raises no exception flags and no traps, and it always uses the standard maximum rules.

A request holds a 64-bit address, the operand, a release flag and a flag that marks the base as the stack pointer. A stack-pointer base must be aligned to 2^`SP_ALIGN_BITS` bytes. If it is not, the request ends with a fault and makes no memory access. Any other base marks the access as tag-checked. The memory side is a simple port with a read phase and then a write phase, and a lock is held across both phases. When the operation finishes, a single-cycle `done` pulse is raised.

Top module: `bf16_atomic_max`

## Requirements
- R1: The value written is the numerically larger of the memory halfword and the operand under BFloat16 ordering: sign, then magnitude; infinities rank above every finite value; subnormals are ordered by value. The write goes to the same address that was read.
- R2: If either input is a NaN (exponent field bits 14..7 all ones and fraction bits 6..0 non-zero), the value written is 16'h7FC0.
- R3: Comparing +0 (16'h0000) with -0 (16'h8000) in either order writes 16'h0000. Two -0 inputs write 16'h8000.
- R4: `memLock` is high from the first cycle of the read request until the cycle in which the write is acknowledged. It is low whenever the unit is idle.
- R5: `done` is high for exactly one cycle, in the cycle after the one in which `memWrAck` is seen during the write phase. It stays low during both memory phases.
- R6: `reqReady` is high only while the unit is idle. A `reqValid` raised while the unit is busy is ignored and does not change the address or the value being written.
- R7: During the write phase `memRelease` equals the release flag of the request. It is 0 during the read phase.
- R8: A request with `reqUseSp`=1 whose address bits [SP_ALIGN_BITS-1:0] are not all zero makes no read and no write. In the next cycle it raises `done` and `fault` together for one cycle. A request with `reqUseSp`=0 is never faulted.
- R9: `memTagChecked` is 1 during both memory phases exactly when the request did not use the stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit idle; a request is taken in this cycle |
| reqAddr | input | 64 | Halfword address |
| reqOperand | input | 16 | BFloat16 register operand |
| reqRelease | input | 1 | Write must carry release ordering |
| reqUseSp | input | 1 | Base register is the stack pointer |
| memAddr | output | 64 | Address for both phases |
| memRdReq | output | 1 | Read phase request |
| memRdAck | input | 1 | Read data valid |
| memRdData | input | 16 | Halfword read from memory |
| memWrReq | output | 1 | Write phase request |
| memWrAck | input | 1 | Write accepted |
| memWrData | output | 16 | Maximum to store |
| memLock | output | 1 | Location locked across the whole sequence |
| memRelease | output | 1 | Release ordering on the current write |
| memTagChecked | output | 1 | Access is tag-checked |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Alignment fault, valid together with done |

## Verification
The assertions assume that memory raises `memRdAck` only while `memRdReq` is high and `memWrAck` only while `memWrReq` is high. They also assume that `memRdData` is valid in the cycle its acknowledge is raised. The bench drives each acknowledge for exactly one cycle, only after it has seen the matching request, and varies the delay before it. A busy-time request is driven only in the read phase, and reqValid is dropped before the read is acknowledged. As a result, no request is presented at the instant the unit returns to idle.

// File: rtl/bfmax_pkg.sv
package bfmax_pkg;
  localparam int BF_W = 16;
  localparam int EXP_W = 8;
  localparam int FRAC_W = BF_W - EXP_W - 1;
  localparam logic [BF_W-1:0] DEFAULT_NAN = 16'h7FC0;

  typedef struct packed {
    logic loadReq;
    logic captureRd;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_FINISH
  } phase_t;

  function automatic logic isNan(input logic [BF_W-1:0] v);
    return (&v[BF_W-2:FRAC_W]) && (|v[FRAC_W-1:0]);
  endfunction

  // Map to an unsigned key whose order matches numeric order (-0 just below +0).
  function automatic logic [BF_W-1:0] orderKey(input logic [BF_W-1:0] v);
    return v[BF_W-1] ? ~v : {1'b1, v[BF_W-2:0]};
  endfunction

  function automatic logic [BF_W-1:0] bfMax(input logic [BF_W-1:0] a,
                                            input logic [BF_W-1:0] b);
    if (isNan(a) || isNan(b)) return DEFAULT_NAN;
    return (orderKey(a) >= orderKey(b)) ? a : b;
  endfunction
endpackage

// File: rtl/bfmax_dp.sv
module bfmax_dp
  import bfmax_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SP_ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BF_W-1:0]   reqOperand,
  input  logic              reqRelease,
  input  logic              reqUseSp,
  input  logic [BF_W-1:0]   memRdData,
  output logic              reqMisaligned,
  output logic [ADDR_W-1:0] addrQ,
  output logic [BF_W-1:0]   resultQ,
  output logic              releaseQ,
  output logic              tagCheckedQ
);
  logic [BF_W-1:0] operandQ;

  generate
    if (SP_ALIGN_BITS == 0) begin : g_noAlign
      assign reqMisaligned = 1'b0;
    end else begin : g_align
      assign reqMisaligned = reqUseSp && (|reqAddr[SP_ALIGN_BITS-1:0]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ       <= '0;
      operandQ    <= '0;
      releaseQ    <= 1'b0;
      tagCheckedQ <= 1'b0;
      resultQ     <= '0;
    end else begin
      if (strobe.loadReq) begin
        addrQ       <= reqAddr;
        operandQ    <= reqOperand;
        releaseQ    <= reqRelease;
        tagCheckedQ <= !reqUseSp;
      end
      if (strobe.captureRd) resultQ <= bfMax(memRdData, operandQ);
    end
  end

  p_nan_default_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureRd && isNan(memRdData)) |=> (resultQ == DEFAULT_NAN));

  p_addr_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadReq |=> ($stable(addrQ) && $stable(releaseQ)));
endmodule

// File: rtl/bfmax_ctrl.sv
module bfmax_ctrl
  import bfmax_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqMisaligned,
  input  logic      memRdAck,
  input  logic      memWrAck,
  output dpStrobe_t strobe,
  output logic      reqReady,
  output logic      memRdReq,
  output logic      memWrReq,
  output logic      memLock,
  output logic      writePhase,
  output logic      done,
  output logic      fault
);
  phase_t state, stateNext;
  logic faultQ;
  logic accept;

  assign accept = reqValid && (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqValid) stateNext = reqMisaligned ? ST_FINISH : ST_READ;
      ST_READ:   if (memRdAck) stateNext = ST_WRITE;
      ST_WRITE:  if (memWrAck) stateNext = ST_FINISH;
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      faultQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) faultQ <= reqMisaligned;
    end
  end

  assign strobe.loadReq   = accept;
  assign strobe.captureRd = (state == ST_READ) && memRdAck;
  assign reqReady   = (state == ST_IDLE);
  assign memRdReq   = (state == ST_READ);
  assign memWrReq   = (state == ST_WRITE);
  assign writePhase = (state == ST_WRITE);
  assign memLock    = (state == ST_READ) || (state == ST_WRITE);
  assign done       = (state == ST_FINISH);
  assign fault      = (state == ST_FINISH) && faultQ;

  p_rd_leads_wr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && memRdAck) |=> (memWrReq && memLock));

  p_rd_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdAck) |=> (memRdReq && memLock));

  p_done_after_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memWrReq && memWrAck) |=> (done && !fault));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_fault_no_access_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqMisaligned) |=> (fault && done && !memRdReq && !memLock));
endmodule

// File: rtl/bf16_atomic_max.sv
module bf16_atomic_max
  import bfmax_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SP_ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqOperand,
  input  logic              reqRelease,
  input  logic              reqUseSp,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdReq,
  input  logic              memRdAck,
  input  logic [15:0]       memRdData,
  output logic              memWrReq,
  input  logic              memWrAck,
  output logic [15:0]       memWrData,
  output logic              memLock,
  output logic              memRelease,
  output logic              memTagChecked,
  output logic              done,
  output logic              fault
);
  dpStrobe_t strobe;
  logic reqMisaligned, releaseQ, writePhase;

  bfmax_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMisaligned(reqMisaligned),
    .memRdAck(memRdAck), .memWrAck(memWrAck), .strobe(strobe), .reqReady(reqReady),
    .memRdReq(memRdReq), .memWrReq(memWrReq), .memLock(memLock),
    .writePhase(writePhase), .done(done), .fault(fault)
  );

  bfmax_dp #(.ADDR_W(ADDR_W), .SP_ALIGN_BITS(SP_ALIGN_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqOperand(reqOperand), .reqRelease(reqRelease), .reqUseSp(reqUseSp),
    .memRdData(memRdData), .reqMisaligned(reqMisaligned), .addrQ(memAddr),
    .resultQ(memWrData), .releaseQ(releaseQ), .tagCheckedQ(memTagChecked)
  );

  assign memRelease = writePhase && releaseQ;

  p_release_only_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> !memRelease);
endmodule

// File: tb/bf16_atomic_max_bench.sv
`timescale 1ns/1ps
module bf16_atomic_max_bench;
  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqRelease = 0, reqUseSp = 0;
  logic [63:0] reqAddr = '0;
  logic [15:0] reqOperand = '0, memRdData = '0;
  logic memRdAck = 0, memWrAck = 0;
  logic reqReady, memRdReq, memWrReq, memLock, memRelease, memTagChecked, done, fault;
  logic [63:0] memAddr;
  logic [15:0] memWrData;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bf16_atomic_max u_bf16_atomic_max (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqOperand(reqOperand), .reqRelease(reqRelease), .reqUseSp(reqUseSp),
    .memAddr(memAddr), .memRdReq(memRdReq), .memRdAck(memRdAck), .memRdData(memRdData),
    .memWrReq(memWrReq), .memWrAck(memWrAck), .memWrData(memWrData), .memLock(memLock),
    .memRelease(memRelease), .memTagChecked(memTagChecked), .done(done), .fault(fault)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sample(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h8000;  2: return 16'h3F80;  3: return 16'hBF80;
      4: return 16'h4000;  5: return 16'hC000;  6: return 16'h7F80;  7: return 16'hFF80;
      8: return 16'h0001;  9: return 16'h8001; 10: return 16'h007F; 11: return 16'h0080;
      12: return 16'h7F7F; 13: return 16'hFF7F; 14: return 16'h3F81; 15: return 16'h7FC0;
      16: return 16'h7F81; 17: return 16'hFFFF; 18: return 16'h4049; default: return 16'hC049;
    endcase
  endfunction

  function automatic bit nanB(input logic [15:0] v);
    return (v[14:7] == 8'hFF) && (v[6:0] != 0);
  endfunction

  function automatic real toReal(input logic [15:0] v);
    real m;
    int e = int'(v[14:7]);
    int f = int'(v[6:0]);
    if (e == 255) m = 1.0e300;
    else if (e == 0) m = f * (2.0 ** -133);
    else m = (128 + f) * (2.0 ** (e - 134));
    return v[15] ? -m : m;
  endfunction

  function automatic logic [15:0] refMax(input logic [15:0] a, input logic [15:0] b);
    real ra, rb;
    if (nanB(a) || nanB(b)) return 16'h7FC0;
    ra = toReal(a); rb = toReal(b);
    if (ra > rb) return a;
    if (rb > ra) return b;
    return (a[15] == 1'b0) ? a : b;
  endfunction

  task automatic doOp(input logic [63:0] addr, input logic [15:0] opnd, input logic [15:0] memVal,
                      input logic rel, input logic sp, input int rdD, input int wrD,
                      input bit expFault, input bit intrude);
    logic [15:0] exp = refMax(memVal, opnd);
    @(negedge clk);
    chk(reqReady == 1'b1, "R6 ready when idle", reqReady, 1);
    reqValid = 1; reqAddr = addr; reqOperand = opnd; reqRelease = rel; reqUseSp = sp;
    @(negedge clk);
    reqValid = 0;
    if (expFault) begin
      chk(done && fault, "R8 fault with done", {done, fault}, 2'b11);
      chk(!memRdReq && !memWrReq && !memLock, "R8 no access", {memRdReq, memWrReq, memLock}, 0);
      @(negedge clk);
      chk(!done && !fault && reqReady, "R8 fault one cycle", {done, fault, reqReady}, 3'b001);
      return;
    end
    chk(!done && !fault, "R8 no fault", {done, fault}, 0);
    for (int k = 0; k < rdD; k++) begin
      chk(memRdReq && memLock && !reqReady, "R4 lock in read", {memRdReq, memLock, reqReady}, 3'b110);
      if (intrude && k == 0) begin
        reqValid = 1; reqAddr = addr ^ 64'h40; reqOperand = 16'h7F7F; reqRelease = !rel;
      end
      @(negedge clk);
    end
    reqValid = 0;
    chk(memRdReq && memLock, "R4 lock at read", {memRdReq, memLock}, 2'b11);
    chk(memAddr == addr, "R1 read address", memAddr, addr);
    chk(memRelease == 1'b0, "R7 no release on read", memRelease, 0);
    chk(memTagChecked == !sp, "R9 tag on read", memTagChecked, !sp);
    chk(!done, "R5 no done in read", done, 0);
    memRdAck = 1; memRdData = memVal;
    @(negedge clk);
    memRdAck = 0; memRdData = 16'h5A5A;
    for (int k = 0; k < wrD; k++) begin
      chk(memWrReq && memLock && !done, "R5 waiting write", {memWrReq, memLock, done}, 3'b110);
      @(negedge clk);
    end
    chk(memWrReq && memLock && !memRdReq, "R4 lock at write", {memWrReq, memLock, memRdReq}, 3'b110);
    if (nanB(memVal) || nanB(opnd))
      chk(memWrData == exp, "R2 default NaN", memWrData, exp);
    else if (memVal[14:0] == 0 && opnd[14:0] == 0)
      chk(memWrData == exp, "R3 signed zero", memWrData, exp);
    else
      chk(memWrData == exp, "R1 maximum", memWrData, exp);
    chk(memAddr == addr, "R6 address unchanged by busy request", memAddr, addr);
    chk(memRelease == rel, "R7 release on write", memRelease, rel);
    chk(memTagChecked == !sp, "R9 tag on write", memTagChecked, !sp);
    memWrAck = 1;
    @(negedge clk);
    memWrAck = 0;
    chk(done && !fault, "R5 done after ack", {done, fault}, 2'b10);
    chk(!memLock && !memWrReq, "R4 lock released", {memLock, memWrReq}, 0);
    @(negedge clk);
    chk(!done && reqReady, "R5 done single", {done, reqReady}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(reqReady && !memLock && !done && !memRdReq && !memWrReq, "R6 reset state",
        {reqReady, memLock, done, memRdReq, memWrReq}, 5'b10000);
    for (int i = 0; i < 20; i++)
      for (int j = 0; j < 20; j++) begin
        int n = i * 20 + j;
        logic sp = n[1];
        logic [63:0] a = sp ? (64'h0000_1000_0000_0000 + 64'(n) * 16) : (64'h2000 + 64'(n) * 2);
        doOp(a, sample(i), sample(j), n[0], sp, n % 3, (n / 3) % 2, 0, 0);
      end
    doOp(64'h8000_0000_0000_0002, 16'h3F80, 16'h4000, 0, 1, 0, 0, 1, 0);
    doOp(64'h0000_0000_0000_7FF8, 16'h3F80, 16'h4000, 1, 1, 1, 0, 1, 0);
    doOp(64'h0000_0000_0000_3006, 16'hBF80, 16'hC000, 1, 0, 1, 1, 0, 0);
    doOp(64'h0000_0000_0000_4000, 16'h3F80, 16'hBF80, 1, 0, 2, 1, 0, 1);
    doOp(64'h0000_0000_0000_4010, 16'hFF80, 16'h8000, 0, 1, 3, 0, 0, 1);
    finished = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule